// File: doc/BRIEF.md
# SPI Initiator with Status and Interrupt Unit

This block is a serial-peripheral-interface controller that always drives the clock. Software places bytes in a transmit queue through a small register bus. The engine shifts each byte out on MOSI, most significant bit first, and captures the byte returned on MISO into a receive queue. A six-bit divider sets the serial clock rate from the system clock. An optional byte count ends a transfer after a set number of bytes and raises a completion flag.

Two sticky status flags can each raise an interrupt: transfer complete and transmit queue drained. Software clears either flag by writing 1 to it. A combined interrupt output is high while any enabled flag is pending. A half-word access mode moves two queue bytes per bus access.

Register map (word offsets on `bus_addr`):
- 0: status.
- 1: receive data.
- 2: transmit data.
- 3: divider, bits [5:0].
- 4: control.
- 5: interrupt enables.
- 6: byte count, bits [13:0].

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset every register reads 0, `cs_n` is 1, `sclk` is 0 and `irq` is 0.
- R2: `sclk` idles low. Each half period of `sclk` lasts exactly (1 + divider) system clock cycles.
- R3: Mode 0 framing applies. MOSI carries each byte MSB first and is stable while `sclk` is high. MISO is sampled at each rising edge of `sclk`. `sclk` is high only while `cs_n` is low.
- R4: `cs_n` falls (1 + divider) cycles before the first rising edge of `sclk`. It rises (1 + divider) cycles after the last falling edge of `sclk`.
- R5: A transfer starts when control bit 0 (enable) is 1 and the transmit queue holds data. Bytes follow each other under one chip select while data remains. Clearing enable stops the transfer on the next cycle, releasing `cs_n` and returning `sclk` low.
- R6: With a non-zero byte count N, status bit 1 (done) sets when the N-th byte of a transfer has been shifted, and that transfer then releases `cs_n`. Done stays set until 1 is written to status bit 1.
- R7: Done never sets while the byte count is 0. Forcing chip select does not set it.
- R8: Status bit 2 (transmit empty) sets when the transmit queue goes from non-empty to empty while enabled. Writing 1 to bit 2 clears it. It is also cleared while enable is 0.
- R9: `irq` = (done AND enable-register bit 13) OR (transmit empty AND enable-register bit 14 AND NOT control bit 13). Status bit 0 reads the same value.
- R10: Each queue holds FIFO_DEPTH bytes. A byte written to a full transmit queue is dropped. Reading an empty receive queue returns 0.
- R11: With control bit 1 (half-word mode) set, a transmit write queues bits [7:0] first and bits [15:8] second. A receive read returns the older byte in [7:0] and the next byte in [15:8]. Outside this mode, receive bits [15:8] read 0.
- R12: Control bit 2 forces `cs_n` low whatever the engine state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (pops receive data) |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq | output | 1 | Combined interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench builds the block with FIFO_DEPTH set to 4 and the default divider and count widths. The shallow queues let five writes overflow the transmit side and four received bytes fill the receive side. The divider is programmed to 1 and to 2, so the timing monitor sees half periods of two and three cycles. A byte count of 2 with three queued bytes shows done setting and chip select releasing mid-stream, followed by a fresh transfer.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_LEAD,
        ENG_LOW,
        ENG_HIGH,
        ENG_TRAIL
    } eng_state_e;

    localparam logic [2:0] A_STAT = 3'd0;
    localparam logic [2:0] A_RXD  = 3'd1;
    localparam logic [2:0] A_TXD  = 3'd2;
    localparam logic [2:0] A_DIV  = 3'd3;
    localparam logic [2:0] A_CTL  = 3'd4;
    localparam logic [2:0] A_IEN  = 3'd5;
    localparam logic [2:0] A_CNT  = 3'd6;

    localparam int CTL_EN    = 0;
    localparam int CTL_HALF  = 1;
    localparam int CTL_FORCE = 2;
    localparam int CTL_MUTE  = 13;

    localparam int IEN_DONE = 13;
    localparam int IEN_TXE  = 14;

    localparam int ST_IRQ  = 0;
    localparam int ST_DONE = 1;
    localparam int ST_TXE  = 2;

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter  int DEPTH = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       push_n,
    input  logic [15:0]      push_data,
    input  logic [1:0]       pop_n,
    output logic [7:0]       head_lo,
    output logic [7:0]       head_hi,
    output logic [LVL_W-1:0] level
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [PTR_W-1:0]      rd;
        logic [PTR_W-1:0]      wr;
        logic [LVL_W-1:0]      lvl;
    } fifo_t;

    fifo_t q, d;
    logic [LVL_W-1:0] take, room, put;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d    = q;
        take = (LVL_W'(pop_n) > q.lvl) ? q.lvl : LVL_W'(pop_n);
        room = LVL_W'(DEPTH) - q.lvl;
        put  = (LVL_W'(push_n) > room) ? room : LVL_W'(push_n);
        if (take >= LVL_W'(1)) d.rd = step(q.rd);
        if (take >= LVL_W'(2)) d.rd = step(d.rd);
        if (put >= LVL_W'(1)) begin
            d.mem[q.wr] = push_data[7:0];
            d.wr        = step(q.wr);
        end
        if (put >= LVL_W'(2)) begin
            d.mem[d.wr] = push_data[15:8];
            d.wr        = step(d.wr);
        end
        d.lvl = q.lvl - take + put;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head_lo = (q.lvl != '0) ? q.mem[q.rd] : 8'h00;
    assign head_hi = (q.lvl >= LVL_W'(2)) ? q.mem[step(q.rd)] : 8'h00;
    assign level   = q.lvl;

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_host_pkg::*;
#(
    parameter int DIV_W = 6,
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] div,
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic             tx_avail,
    input  logic [7:0]       tx_byte,
    input  logic             miso,
    output logic             tx_pop,
    output logic             rx_push,
    output logic [7:0]       rx_byte,
    output logic             done_pulse,
    output logic             sclk,
    output logic             mosi,
    output logic             csn
);
    typedef struct packed {
        eng_state_e       st;
        logic [DIV_W-1:0] tick;
        logic [2:0]       bitn;
        logic [7:0]       txsh;
        logic [7:0]       rxsh;
        logic [CNT_W-1:0] sent;
        logic             sclk;
        logic             csn;
    } eng_t;

    eng_t q, d;
    logic expire;

    always_comb begin
        d          = q;
        tx_pop     = 1'b0;
        rx_push    = 1'b0;
        done_pulse = 1'b0;
        expire     = (q.tick == '0);
        if (!enable) begin
            d.st   = ENG_IDLE;
            d.sclk = 1'b0;
            d.csn  = 1'b1;
        end else begin
            unique case (q.st)
                ENG_IDLE: begin
                    if (tx_avail) begin
                        tx_pop = 1'b1;
                        d.txsh = tx_byte;
                        d.bitn = '0;
                        d.sent = '0;
                        d.tick = div;
                        d.csn  = 1'b0;
                        d.st   = ENG_LEAD;
                    end
                end
                ENG_LEAD, ENG_LOW: begin
                    if (expire) begin
                        d.sclk = 1'b1;
                        d.rxsh = {q.rxsh[6:0], miso};
                        d.tick = div;
                        d.st   = ENG_HIGH;
                    end else begin
                        d.tick = q.tick - 1'b1;
                    end
                end
                ENG_HIGH: begin
                    if (expire) begin
                        d.sclk = 1'b0;
                        d.tick = div;
                        if (q.bitn == 3'd7) begin
                            rx_push = 1'b1;
                            d.sent  = q.sent + CNT_W'(1);
                            if ((byte_cnt != '0) && (d.sent == byte_cnt)) begin
                                done_pulse = 1'b1;
                                d.st       = ENG_TRAIL;
                            end else if (tx_avail) begin
                                tx_pop = 1'b1;
                                d.txsh = tx_byte;
                                d.bitn = '0;
                                d.st   = ENG_LOW;
                            end else begin
                                d.st = ENG_TRAIL;
                            end
                        end else begin
                            d.txsh = {q.txsh[6:0], 1'b0};
                            d.bitn = q.bitn + 3'd1;
                            d.st   = ENG_LOW;
                        end
                    end else begin
                        d.tick = q.tick - 1'b1;
                    end
                end
                ENG_TRAIL: begin
                    if (expire) begin
                        d.csn = 1'b1;
                        d.st  = ENG_IDLE;
                    end else begin
                        d.tick = q.tick - 1'b1;
                    end
                end
                default: d.st = ENG_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.csn <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rx_byte = q.rxsh;
    assign sclk    = q.sclk;
    assign mosi    = q.txsh[7];
    assign csn     = q.csn;

endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
    import spi_host_pkg::*;
#(
    parameter  int FIFO_DEPTH = 8,
    parameter  int DIV_W      = 6,
    parameter  int CNT_W      = 14,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    input  logic        bus_we,
    input  logic        bus_re,
    output logic [15:0] bus_rdata,
    output logic        irq,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic        cs_n
);
    typedef struct packed {
        logic             en;
        logic             half;
        logic             force_cs;
        logic             mute_txe;
        logic             ie_done;
        logic             ie_txe;
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] cnt;
        logic             st_done;
        logic             st_txe;
        logic             tx_had;
    } regs_t;

    regs_t q, d;

    logic [1:0]       tx_push_n, rx_pop_n;
    logic [7:0]       tx_head, tx_head_hi, rx_lo, rx_hi, rx_byte;
    logic [LVL_W-1:0] tx_level, rx_level;
    logic             tx_pop, rx_push, done_pulse, eng_csn;
    logic             wr_stat, txe_evt;
    logic             st_done_w, st_txe_w, en_w;
    logic [CNT_W-1:0] cnt_w;

    assign tx_push_n = (bus_we && bus_addr == A_TXD) ? (q.half ? 2'd2 : 2'd1) : 2'd0;
    assign rx_pop_n  = (bus_re && bus_addr == A_RXD) ? (q.half ? 2'd2 : 2'd1) : 2'd0;

    spi_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push_n(tx_push_n), .push_data(bus_wdata),
        .pop_n({1'b0, tx_pop}),
        .head_lo(tx_head), .head_hi(tx_head_hi), .level(tx_level)
    );

    spi_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push_n({1'b0, rx_push}), .push_data({8'h00, rx_byte}),
        .pop_n(rx_pop_n),
        .head_lo(rx_lo), .head_hi(rx_hi), .level(rx_level)
    );

    spi_shift_engine #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .enable(q.en), .div(q.div), .byte_cnt(q.cnt),
        .tx_avail(tx_level != '0), .tx_byte(tx_head), .miso(miso),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_byte(rx_byte),
        .done_pulse(done_pulse),
        .sclk(sclk), .mosi(mosi), .csn(eng_csn)
    );

    always_comb begin
        d       = q;
        wr_stat = bus_we && (bus_addr == A_STAT);
        txe_evt = q.tx_had && (tx_level == '0);
        if (bus_we) begin
            unique case (bus_addr)
                A_DIV: d.div = bus_wdata[DIV_W-1:0];
                A_CNT: d.cnt = bus_wdata[CNT_W-1:0];
                A_CTL: begin
                    d.en       = bus_wdata[CTL_EN];
                    d.half     = bus_wdata[CTL_HALF];
                    d.force_cs = bus_wdata[CTL_FORCE];
                    d.mute_txe = bus_wdata[CTL_MUTE];
                end
                A_IEN: begin
                    d.ie_done = bus_wdata[IEN_DONE];
                    d.ie_txe  = bus_wdata[IEN_TXE];
                end
                default: ;
            endcase
        end
        d.tx_had  = (tx_level != '0);
        d.st_done = done_pulse || (q.st_done && !(wr_stat && bus_wdata[ST_DONE]));
        d.st_txe  = q.en && (txe_evt || (q.st_txe && !(wr_stat && bus_wdata[ST_TXE])));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign irq  = (q.st_done && q.ie_done) || (q.st_txe && q.ie_txe && !q.mute_txe);
    assign cs_n = eng_csn && !q.force_cs;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_STAT: begin
                bus_rdata[ST_IRQ]  = irq;
                bus_rdata[ST_DONE] = q.st_done;
                bus_rdata[ST_TXE]  = q.st_txe;
            end
            A_RXD: bus_rdata = {q.half ? rx_hi : 8'h00, rx_lo};
            A_DIV: bus_rdata = 16'(q.div);
            A_CNT: bus_rdata = 16'(q.cnt);
            A_CTL: begin
                bus_rdata[CTL_EN]    = q.en;
                bus_rdata[CTL_HALF]  = q.half;
                bus_rdata[CTL_FORCE] = q.force_cs;
                bus_rdata[CTL_MUTE]  = q.mute_txe;
            end
            A_IEN: begin
                bus_rdata[IEN_DONE] = q.ie_done;
                bus_rdata[IEN_TXE]  = q.ie_txe;
            end
            default: bus_rdata = '0;
        endcase
    end

    assign st_done_w = q.st_done;
    assign st_txe_w  = q.st_txe;
    assign en_w      = q.en;
    assign cnt_w     = q.cnt;

endmodule

// File: rtl/spi_host_ctrl_chk.sv
module spi_host_ctrl_chk #(
    parameter  int DEPTH = 8,
    parameter  int CNT_W = 14,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sclk,
    input logic             mosi,
    input logic             cs_n,
    input logic             irq,
    input logic             done_pulse,
    input logic             st_done,
    input logic             st_txe,
    input logic             en,
    input logic [CNT_W-1:0] cnt,
    input logic [LVL_W-1:0] tx_level
);
    a_r3_sclk_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    a_r3_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    a_r6_done_latches: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> st_done);

    a_r7_done_needs_count: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (cnt != '0));

    a_r8_txe_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !st_txe);

    a_r9_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (st_done || st_txe));

    a_r10_tx_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= LVL_W'(DEPTH));
endmodule

bind spi_host_ctrl spi_host_ctrl_chk #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .irq(irq),
    .done_pulse(done_pulse), .st_done(st_done_w), .st_txe(st_txe_w),
    .en(en_w), .cnt(cnt_w), .tx_level(tx_level)
);

// File: tb/spi_host_ctrl_tb.sv
module spi_host_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;

    logic        clk = 0, rst_n = 0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic        bus_we = 0, bus_re = 0;
    logic        irq, sclk, mosi, cs_n;
    logic        miso = 0;

    int checks = 0, errors = 0;
    int hp = 1;
    bit timing_on = 0;
    int gap = 0;
    logic p_sclk = 0, p_csn = 1, p_mosi = 0;

    logic [7:0] got[$];
    logic [7:0] rx_sent[$];
    logic [7:0] pat = 8'h3C, miso_cur = 0, out_sh = 0, in_sh = 0;
    int bitc = 0;
    int cs_rises = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_host_ctrl #(.FIFO_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .irq(irq),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural target device
    always @(negedge cs_n) begin
        miso_cur = pat; pat = pat + 8'h1D; out_sh = miso_cur; miso = out_sh[7]; bitc = 0;
    end
    always @(posedge sclk) begin
        in_sh = {in_sh[6:0], mosi};
        bitc++;
        if (bitc == 8) begin
            got.push_back(in_sh);
            rx_sent.push_back(miso_cur);
            bitc = 0;
        end
    end
    always @(negedge sclk) begin
        if (bitc == 0) begin
            miso_cur = pat; pat = pat + 8'h1D; out_sh = miso_cur;
        end else begin
            out_sh = {out_sh[6:0], 1'b0};
        end
        miso = out_sh[7];
    end
    always @(posedge cs_n) cs_rises++;

    // per-clock reference of the serial timing
    always @(negedge clk) begin
        if (rst_n) begin
            gap++;
            if (sclk !== p_sclk || cs_n !== p_csn) begin
                if (timing_on && p_csn == 1'b0)
                    chk(gap == hp, "R2/R4 edge interval", gap, hp);
                gap = 0;
            end
            if (timing_on && sclk && p_sclk && mosi !== p_mosi)
                chk(0, "R3 mosi moved while sclk high", mosi, p_mosi);
            if (timing_on && sclk && cs_n)
                chk(0, "R3 sclk high outside frame", cs_n, 0);
            p_sclk = sclk; p_csn = cs_n; p_mosi = mosi;
        end
    end

    task automatic bus_wr(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_we = 1;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_addr = a; bus_re = 1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_re = 0;
    endtask

    task automatic wait_bytes(input int n);
        while (got.size() < n) @(negedge clk);
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 4 * hp + 6) begin
            @(negedge clk);
            quiet = cs_n ? quiet + 1 : 0;
        end
    endtask

    task automatic rx_expect(input string req);
        logic [15:0] v;
        logic [7:0] e;
        bus_rd(3'd1, v);
        e = rx_sent.pop_front();
        chk(v == {8'h00, e}, req, v, {8'h00, e});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(cs_n == 1 && sclk == 0 && irq == 0, "R1 pins after reset", {cs_n, sclk, irq}, 3'b100);
        bus_rd(3'd0, v); chk(v == 0, "R1 status reset", v, 0);
        bus_rd(3'd4, v); chk(v == 0, "R1 control reset", v, 0);
        bus_rd(3'd3, v); chk(v == 0, "R1 divider reset", v, 0);
        bus_rd(3'd1, v); chk(v == 0, "R10 empty rx read", v, 0);

        // single byte, divider 1, transmit-empty interrupt
        hp = 2; timing_on = 1;
        bus_wr(3'd3, 16'd1);
        bus_wr(3'd5, 16'h4000);
        bus_wr(3'd4, 16'h0001);
        bus_wr(3'd2, 16'h00A5);
        wait_bytes(1); wait_idle();
        chk(got[0] == 8'hA5, "R3 mosi byte", got[0], 8'hA5);
        rx_expect("R3/R11 rx byte, upper zero");
        bus_rd(3'd0, v); chk(v == 16'h0005, "R8 txe set, R9 summary", v, 16'h0005);
        chk(irq == 1, "R9 irq txe", irq, 1);
        bus_wr(3'd0, 16'h0004);
        bus_rd(3'd0, v); chk(v == 0, "R8 w1c txe", v, 0);
        chk(irq == 0, "R9 irq cleared", irq, 0);

        // muted transmit-empty interrupt
        bus_wr(3'd4, 16'h2001);
        bus_wr(3'd2, 16'h005A);
        wait_bytes(2); wait_idle();
        chk(got[1] == 8'h5A, "R5 second transfer", got[1], 8'h5A);
        bus_rd(3'd0, v); chk(v == 16'h0004, "R9 mute blocks irq", v, 16'h0004);
        chk(irq == 0, "R9 irq muted", irq, 0);
        rx_expect("R3 rx byte muted run");
        bus_wr(3'd0, 16'h0004);

        // byte count 2 with three bytes queued, divider 2
        hp = 3;
        bus_wr(3'd4, 16'h0000);
        bus_wr(3'd3, 16'd2);
        bus_wr(3'd6, 16'd2);
        bus_wr(3'd5, 16'h2000);
        base = got.size();
        v = 16'(cs_rises);
        bus_wr(3'd2, 16'h0011); bus_wr(3'd2, 16'h0022); bus_wr(3'd2, 16'h0033);
        bus_wr(3'd4, 16'h0001);
        wait_bytes(base + 1);
        begin
            logic [15:0] s;
            bus_rd(3'd0, s); chk(s[1] == 0, "R6 done not early", s[1], 0);
        end
        wait_bytes(base + 3); wait_idle();
        chk(got[base] == 8'h11 && got[base+1] == 8'h22 && got[base+2] == 8'h33,
            "R5 byte order", {got[base], got[base+1], got[base+2]}, 24'h112233);
        chk(cs_rises - int'(v) == 2, "R6 count ends transfer", cs_rises - int'(v), 2);
        begin
            logic [15:0] s;
            bus_rd(3'd0, s); chk(s == 16'h0007, "R6 done set, R9 summary", s, 16'h0007);
            chk(irq == 1, "R9 irq done", irq, 1);
            bus_wr(3'd0, 16'h0002);
            bus_rd(3'd0, s); chk(s == 16'h0004, "R6 w1c done", s, 16'h0004);
            chk(irq == 0, "R9 irq after done clear", irq, 0);
        end
        rx_expect("R5 rx 1"); rx_expect("R5 rx 2"); rx_expect("R5 rx 3");

        // count zero: done never sets
        bus_wr(3'd6, 16'd0);
        base = got.size();
        bus_wr(3'd2, 16'h0044); bus_wr(3'd2, 16'h0055);
        wait_bytes(base + 2); wait_idle();
        bus_rd(3'd0, v); chk(v[1] == 0, "R7 no done with zero count", v[1], 0);
        rx_expect("R7 rx 1"); rx_expect("R7 rx 2");

        // chip select force
        timing_on = 0;
        bus_wr(3'd6, 16'd1);
        bus_wr(3'd4, 16'h0005);
        repeat (20) @(negedge clk);
        chk(cs_n == 0 && sclk == 0, "R12 forced select", {cs_n, sclk}, 2'b00);
        bus_rd(3'd0, v); chk(v[1] == 0, "R7 force does not set done", v[1], 0);
        bus_wr(3'd4, 16'h0001);
        @(negedge clk);
        chk(cs_n == 1, "R12 force released", cs_n, 1);
        wait_idle();
        timing_on = 1;

        // enable cleared drops transmit-empty; overflow of transmit queue
        bus_wr(3'd6, 16'd0);
        bus_rd(3'd0, v); chk(v[2] == 1, "R8 txe pending before disable", v[2], 1);
        bus_wr(3'd4, 16'h0000);
        bus_rd(3'd0, v); chk(v[2] == 0, "R8 disable clears txe", v[2], 0);
        base = got.size();
        for (int i = 0; i < 5; i++) bus_wr(3'd2, 16'(8'h10 + i));
        bus_wr(3'd4, 16'h0001);
        wait_bytes(base + 4); wait_idle();
        chk(got.size() == base + 4, "R10 fifth byte dropped", got.size() - base, 4);
        chk(got[base+3] == 8'h13, "R10 last kept byte", got[base+3], 8'h13);
        for (int i = 0; i < 4; i++) rx_expect("R10 full rx drain");
        bus_rd(3'd1, v); chk(v == 0, "R10 empty rx after drain", v, 0);

        // half-word mode
        bus_wr(3'd4, 16'h0002);
        base = got.size();
        bus_wr(3'd2, 16'h1234);
        bus_wr(3'd4, 16'h0003);
        wait_bytes(base + 2); wait_idle();
        chk(got[base] == 8'h34 && got[base+1] == 8'h12, "R11 low byte first",
            {got[base], got[base+1]}, 16'h3412);
        begin
            logic [7:0] e0, e1;
            e0 = rx_sent.pop_front(); e1 = rx_sent.pop_front();
            bus_rd(3'd1, v); chk(v == {e1, e0}, "R11 paired rx read", v, {e1, e0});
        end

        // abort by clearing enable
        timing_on = 0;
        bus_wr(3'd4, 16'h0001);
        base = got.size();
        bus_wr(3'd2, 16'h0077);
        while (!sclk) @(negedge clk);
        bus_wr(3'd4, 16'h0000);
        @(negedge clk);
        chk(cs_n == 1 && sclk == 0, "R5 abort releases pins", {cs_n, sclk}, 2'b10);
        repeat (30) @(negedge clk);
        chk(got.size() == base, "R5 abort no byte", got.size() - base, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule